// File: doc/BRIEF.md
# Programmable Four-Input Function Generator with Residue Data Lines

This block evaluates an arbitrary Boolean function of four inputs using a single eight-way selection stage. Three of the inputs, a, b and c, form the select value. The fourth input, d, is not used for selection. Each of the eight data lines instead resolves to one of four values: constant 0, constant 1, d, or the inverse of d.

To program a function, take the two truth-table rows that share the same a, b and c values. If the function is equal for both rows, that line's code is the matching constant. If the function follows d across the pair, the code is pass-d. If it follows the inverse of d, the code is invert-d.

The eight 2-bit codes live in a small configuration store. A host can rewrite one code per clock through a write port while evaluation continues, so the function can be replaced on the fly. An active-low enable gates the result. The output stage is either registered or combinational, chosen by a parameter.

Top module: `resmux_fgen`

## Requirements
- R1: The select value is `sel`, with `sel[2]` carrying input a (most significant bit) and `sel[0]` carrying input c. Select value k picks data line k, so an all-zero select picks line 0.
- R2: A line holding code 2'b00 resolves to 0, and a line holding code 2'b01 resolves to 1, whatever the value of `in_d`.
- R3: A line holding code 2'b10 resolves to `in_d`, and a line holding code 2'b11 resolves to the inverse of `in_d`.
- R4: While `strobe_n` is high, the function output is 0 whatever the selected line holds.
- R5: When `wr_en` is high at a rising clock edge, `wr_code` is stored into line `wr_addr` at that edge, and every other line keeps its code. The output produced at that same edge still uses the previous code. The new code is in use from the following edge.
- R6: When `wr_en` is low, the values on `wr_addr` and `wr_code` change no stored code.
- R7: A synchronous active-high `rst` sets all eight codes to 2'b00 and clears a registered output. After reset, the output is 0 for every input pattern until a code is written.
- R8: With `REG_OUT` = 1, `f_out` shows, one clock after each rising edge, the value selected by the inputs that were sampled at that edge. With `REG_OUT` = 0, `f_out` follows the inputs with no clock.
- R9: When the line codes are derived from a 16-entry truth table indexed by {a,b,c,d}, the output matches that table for all 16 input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the code store |
| wr_addr | input | SEL_W (3) | Line whose code is written |
| wr_code | input | 2 | Code to write: 00 zero, 01 one, 10 d, 11 not-d |
| sel | input | SEL_W (3) | Select value {a,b,c}, with a in the top bit |
| in_d | input | 1 | Residue input d |
| strobe_n | input | 1 | Active-low output enable |
| f_out | output | 1 | Function result |

## Verification
The bench builds the block with its defaults: `SEL_W` = 3, which gives eight lines, and `REG_OUT` = 1, the registered output. The one-cycle latency of the registered output is therefore what the scoreboard expects. This configuration makes every code value, every line address, both values of d, and a full 16-row sweep reachable. Two unrelated truth tables are loaded one after the other, so reprogramming during operation is exercised. A mid-run reset tests that the store is cleared again. Cycle-exact checks cover the edge where a write lands and the stores that leave the codes unchanged.

// File: rtl/resmux_pkg.sv
package resmux_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    RC_ZERO   = 2'b00,
    RC_ONE    = 2'b01,
    RC_PASS_D = 2'b10,
    RC_INV_D  = 2'b11
  } rcode_t;

  // Resolve one line's code against the residue input.
  function automatic logic resolve_code(input rcode_t code, input logic d);
    logic r;
    case (code)
      RC_ZERO:   r = 1'b0;
      RC_ONE:    r = 1'b1;
      RC_PASS_D: r = d;
      default:   r = ~d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/resmux_cfg_regs.sv
module resmux_cfg_regs
  import resmux_pkg::*;
#(
  parameter int SEL_W     = 3,
  localparam int NUM_LINES = 1 << SEL_W,
  localparam int CFG_W     = NUM_LINES * CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_addr,
  input  logic [CODE_W-1:0]  wr_code,
  output logic [CFG_W-1:0]   cfg_flat
);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic          hit;
    rcode_t        code_q;
    assign hit = wr_en && (wr_addr == SEL_W'(k));
    always_ff @(posedge clk) begin
      if (rst)       code_q <= RC_ZERO;
      else if (hit)  code_q <= rcode_t'(wr_code);
    end
    assign cfg_flat[k*CODE_W +: CODE_W] = code_q;
  end

endmodule

// File: rtl/resmux_line_decode.sv
module resmux_line_decode
  import resmux_pkg::*;
#(
  parameter int SEL_W     = 3,
  localparam int NUM_LINES = 1 << SEL_W,
  localparam int CFG_W     = NUM_LINES * CODE_W
) (
  input  logic [CFG_W-1:0]     cfg_flat,
  input  logic                 in_d,
  output logic [NUM_LINES-1:0] line_val
);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_dec
    assign line_val[k] = resolve_code(rcode_t'(cfg_flat[k*CODE_W +: CODE_W]), in_d);
  end

endmodule

// File: rtl/resmux_sel_tree.sv
module resmux_sel_tree #(
  parameter int SEL_W     = 3,
  localparam int NUM_LINES = 1 << SEL_W,
  localparam int NODES     = 2 * NUM_LINES - 1
) (
  input  logic [NUM_LINES-1:0] line_val,
  input  logic [SEL_W-1:0]     sel,
  output logic                 sel_val
);

  // Heap-ordered binary tree: leaves hold lines, root uses the top select bit.
  logic [NODES-1:0] node;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_leaf
    assign node[NUM_LINES-1+k] = line_val[k];
  end

  for (genvar lv = 0; lv < SEL_W; lv++) begin : g_lvl
    for (genvar j = 0; j < (1 << lv); j++) begin : g_node
      localparam int IDX = (1 << lv) - 1 + j;
      assign node[IDX] = sel[SEL_W-1-lv] ? node[2*IDX+2] : node[2*IDX+1];
    end
  end

  assign sel_val = node[0];

endmodule

// File: rtl/resmux_out_stage.sv
module resmux_out_stage #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_val,
  input  logic strobe_n,
  output logic f_out
);

  logic gated;
  assign gated = sel_val & ~strobe_n;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) f_out <= 1'b0;
      else     f_out <= gated;
    end
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign f_out = gated;
  end

endmodule

// File: rtl/resmux_fgen.sv
module resmux_fgen
  import resmux_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_addr,
  input  logic [CODE_W-1:0]  wr_code,
  input  logic [SEL_W-1:0]   sel,
  input  logic               in_d,
  input  logic               strobe_n,
  output logic               f_out
);

  localparam int NUM_LINES = 1 << SEL_W;
  localparam int CFG_W     = NUM_LINES * CODE_W;

  // Named internal events for the checker.
  logic [CFG_W-1:0]     cfg_flat;
  logic [NUM_LINES-1:0] line_val;
  logic                 sel_val;
  logic [CODE_W-1:0]    sel_code;

  assign sel_code = cfg_flat[sel*CODE_W +: CODE_W];

  resmux_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_code(wr_code), .cfg_flat(cfg_flat)
  );

  resmux_line_decode #(.SEL_W(SEL_W)) u_dec (
    .cfg_flat(cfg_flat), .in_d(in_d), .line_val(line_val)
  );

  resmux_sel_tree #(.SEL_W(SEL_W)) u_tree (
    .line_val(line_val), .sel(sel), .sel_val(sel_val)
  );

  resmux_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .sel_val(sel_val), .strobe_n(strobe_n), .f_out(f_out)
  );

endmodule

// File: rtl/resmux_fgen_chk.sv
module resmux_fgen_chk #(
  parameter int SEL_W   = 3,
  parameter bit REG_OUT = 1'b1,
  localparam int NUM_LINES = 1 << SEL_W,
  localparam int CFG_W     = NUM_LINES * 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [SEL_W-1:0]   wr_addr,
  input logic [1:0]         wr_code,
  input logic [SEL_W-1:0]   sel,
  input logic               in_d,
  input logic               strobe_n,
  input logic               f_out,
  input logic [CFG_W-1:0]   cfg_flat,
  input logic [NUM_LINES-1:0] line_val,
  input logic               sel_val,
  input logic [1:0]         sel_code
);

  function automatic logic [1:0] code_at(input logic [CFG_W-1:0] flat, input int idx);
    return flat[idx*2 +: 2];
  endfunction

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> code_at(cfg_flat, int'($past(wr_addr))) == $past(wr_code));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_flat));

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (cfg_flat == '0));

  assert_pass_d_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b10) |-> (sel_val == in_d));

  assert_inv_d_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_code == 2'b11) |-> (sel_val == !in_d));

  assert_const_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_code[1] == 1'b0) |-> (sel_val == sel_code[0]));

  assert_pick_line_R1: assert property (@(posedge clk) disable iff (rst)
    sel_val == line_val[sel]);

  if (REG_OUT) begin : g_reg_chk
    assert_strobe_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      strobe_n |=> !f_out);
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
      !strobe_n |=> f_out == $past(sel_val));
  end else begin : g_comb_chk
    assert_strobe_blocks_R4: assert property (@(posedge clk) disable iff (rst)
      strobe_n |-> !f_out);
    assert_follow_R8: assert property (@(posedge clk) disable iff (rst)
      !strobe_n |-> f_out == sel_val);
  end

endmodule

bind resmux_fgen resmux_fgen_chk #(.SEL_W(SEL_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
  .sel(sel), .in_d(in_d), .strobe_n(strobe_n), .f_out(f_out),
  .cfg_flat(cfg_flat), .line_val(line_val), .sel_val(sel_val), .sel_code(sel_code)
);

// File: tb/sim_resmux_fgen.sv
module sim_resmux_fgen;
  localparam int CLK_P = 10;
  localparam logic [15:0] TT1 = 16'hB6C9;
  localparam logic [15:0] TT2 = 16'h3A5E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [1:0] wr_code = '0;
  logic [2:0] sel = '0;
  logic in_d = 1'b0;
  logic strobe_n = 1'b0;
  logic f_out;

  always #(CLK_P/2) clk = ~clk;

  resmux_fgen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code),
    .sel(sel), .in_d(in_d), .strobe_n(strobe_n), .f_out(f_out)
  );

  bit    exp_q[$];
  string tag_q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Monitor: one expected item per clock, compared after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (f_out !== e) begin
        fails++;
        $display("FAIL %s f_out=%b expected=%b at %0t", t, f_out, e, $time);
      end
    end
  end

  // Code from a truth-table pair (rows {g,0} and {g,1}).
  function automatic logic [1:0] code_of(input logic [15:0] tt, input int g);
    logic r0, r1;
    r0 = tt[2*g];
    r1 = tt[2*g+1];
    if (r0 == r1) return r0 ? 2'b01 : 2'b00;
    return r1 ? 2'b10 : 2'b11;
  endfunction

  task automatic probe(input logic [2:0] s, input logic dv, input logic sn,
                       input bit e, input string t);
    @(negedge clk);
    wr_en = 1'b0; sel = s; in_d = dv; strobe_n = sn;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  // Write with strobe high: output must be forced low (R4).
  task automatic put_code(input logic [2:0] a, input logic [1:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_code = c; strobe_n = 1'b1;
    exp_q.push_back(1'b0); tag_q.push_back("R4");
  endtask

  task automatic load_table(input logic [15:0] tt);
    for (int g = 0; g < 8; g++) put_code(3'(g), code_of(tt, g));
  endtask

  task automatic sweep(input logic [15:0] tt);
    for (int m = 0; m < 16; m++) probe(3'(m >> 1), m[0], 1'b0, tt[m], "R9");
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    probe(3'd0, 1'b1, 1'b0, 1'b0, "R7");       // output cleared in reset
    @(negedge clk); rst = 1'b0;
    // R7: all codes cleared -> 0 everywhere
    for (int s = 0; s < 8; s++) probe(3'(s), 1'b1, 1'b0, 1'b0, "R7");

    // R1/R2: three-variable function, lines 0,3,4,5,6 are 1
    for (int s = 0; s < 8; s++)
      put_code(3'(s), (s == 0 || s == 3 || s == 4 || s == 5 || s == 6) ? 2'b01 : 2'b00);
    for (int s = 0; s < 8; s++) begin
      bit e;
      e = (s == 0 || s == 3 || s == 4 || s == 5 || s == 6);
      probe(3'(s), 1'b0, 1'b0, e, "R1");
      probe(3'(s), 1'b1, 1'b0, e, "R2");
    end
    // R4: strobe high blocks a line holding 1
    probe(3'd0, 1'b1, 1'b1, 1'b0, "R4");
    probe(3'd4, 1'b0, 1'b1, 1'b0, "R4");

    // R9: first table
    load_table(TT1);
    sweep(TT1);

    // R3: pass and invert
    put_code(3'd2, 2'b10);
    put_code(3'd5, 2'b11);
    probe(3'd2, 1'b0, 1'b0, 1'b0, "R3");
    probe(3'd2, 1'b1, 1'b0, 1'b1, "R3");
    probe(3'd5, 1'b0, 1'b0, 1'b1, "R3");
    probe(3'd5, 1'b1, 1'b0, 1'b0, "R3");

    // R9: reprogram with a second table
    load_table(TT2);
    sweep(TT2);

    // R8: alternating values, one-cycle latency
    probe(3'd6, 1'b0, 1'b0, TT2[12], "R8");
    probe(3'd6, 1'b1, 1'b0, TT2[13], "R8");
    probe(3'd0, 1'b1, 1'b0, TT2[1], "R8");

    // R5: write line 1 to 01 while reading it; old code used at that edge
    @(negedge clk);
    sel = 3'd1; in_d = 1'b0; strobe_n = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd1; wr_code = 2'b01;
    exp_q.push_back(TT2[2]); tag_q.push_back("R5");
    probe(3'd1, 1'b0, 1'b0, 1'b1, "R5");
    probe(3'd0, 1'b0, 1'b0, TT2[0], "R5");     // neighbour untouched
    probe(3'd2, 1'b1, 1'b0, TT2[5], "R5");

    // R6: address/code toggled with write low
    @(negedge clk);
    sel = 3'd1; in_d = 1'b0; strobe_n = 1'b0;
    wr_en = 1'b0; wr_addr = 3'd1; wr_code = 2'b00;
    exp_q.push_back(1'b1); tag_q.push_back("R6");
    @(negedge clk);
    wr_addr = 3'd0; wr_code = 2'b11;
    exp_q.push_back(1'b1); tag_q.push_back("R6");
    probe(3'd1, 1'b0, 1'b0, 1'b1, "R6");
    probe(3'd0, 1'b0, 1'b0, TT2[0], "R6");

    // R7: mid-run reset clears codes
    @(negedge clk); rst = 1'b1;
    probe(3'd1, 1'b0, 1'b0, 1'b0, "R7");
    @(negedge clk); rst = 1'b0;
    probe(3'd1, 1'b0, 1'b0, 1'b0, "R7");
    probe(3'd0, 1'b1, 1'b0, 1'b0, "R7");

    @(negedge clk);
    repeat (2) @(posedge clk);
    #2;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule